// File: doc/BRIEF.md
# Static Memory Bank Controller

This block is an AHB slave that serves single read and write transfers to up to four external static memory banks. Three banks hold SRAM and the highest bank holds a boot ROM. Each accepted transfer is decoded into one active-low chip select. A remap input chooses whether address region zero reaches the boot ROM or the first RAM bank. The block then runs a fixed setup, strobe and recover sequence on a shared external address and data path, and returns the result on the AHB data phase.

Back-pressure works through `hready`. A transfer is taken only in a cycle where `hready` is high, `hsel` is high and `htrans` is NONSEQ or SEQ. `hready` then stays low until the external access is over. The master must hold `hwdata` valid in the first cycle after acceptance. Per-bank wait-state counts are static inputs and stretch only the strobe phase.

Top module: `static_mem_ctrl`

## Requirements
- R1: The bank is chosen by `haddr[29:28]`. Banks 0 to 2 are RAM and bank 3 is the boot ROM.
- R2: While `remap` is 0, region 0 (`haddr[29:28]`=0) selects bank 3. While `remap` is 1, region 0 selects bank 0.
- R3: Chip selects are active low. Exactly one is low, and held steady, in every cycle that `hready` is low during an access. All are high whenever `hready` is high, including after reset.
- R4: The active-low write enables cover the written byte lanes only. `hsize`=0 enables lane `haddr[1:0]`. `hsize`=1 enables lanes 1:0 when `haddr[1]`=0 and lanes 3:2 when it is 1. `hsize`=2 enables all four lanes. Lane k carries `hwdata[8k+7:8k]`.
- R5: `mem_addr` equals `haddr[27:2]`. The two low byte-address bits never reach the external bus.
- R6: While an access runs, `acc_cmd` shows the access kind: 00 for a RAM write, 01 for a RAM read, 10 for a ROM read, and 11 for a write aimed at the ROM, which is discarded.
- R7: With no wait states, `hready` is low for exactly 3 cycles after the accepting edge and high in the 4th cycle. The transfer completes 4 clock edges after acceptance.
- R8: Bank b adds `bank_wait[4b+3:4b]` (0 to 15) extra cycles to that low period.
- R9: A write to the ROM bank asserts no write enable, leaves ROM content unchanged, and completes with an OKAY response after the normal latency.
- R10: On a read, `hrdata` in the completing cycle equals the word the selected device drove on `mem_rdata` at the end of the strobe phase.
- R11: `mem_wdata_oe` is high only while write enables are low. `mem_oe_n` is low only for reads and never together with `mem_wdata_oe`.
- R12: `hresp` is always OKAY (0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsel | input | 1 | Slave select |
| haddr | input | 32 | Transfer byte address |
| htrans | input | 2 | Transfer type; bit 1 marks a real transfer |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | 0 byte, 1 halfword, 2 word |
| hwdata | input | 32 | Write data (data phase) |
| hrdata | output | 32 | Read data |
| hready | output | 1 | Transfer done / slave ready |
| hresp | output | 1 | Response, always OKAY |
| remap | input | 1 | Memory map mode; 0 maps boot ROM at region 0 |
| bank_wait | input | 16 | Four 4-bit wait-state counts, bank 0 in bits 3:0 |
| mem_cs_n | output | 4 | Active-low bank chip selects |
| mem_we_n | output | 4 | Active-low byte-lane write enables |
| mem_oe_n | output | 1 | Active-low output enable for reads |
| mem_addr | output | 26 | External word address |
| mem_wdata | output | 32 | Shared write data |
| mem_wdata_oe | output | 1 | Write data drive enable |
| mem_rdata | input | 32 | Shared read data from the selected device |
| acc_cmd | output | 2 | Current access command code |

## Verification
Every transfer is accepted at one clock edge. The chip select, address and command are due in the very next cycle. `hready` must then stay low for 3 plus the bank's wait count cycles. Read data is due in the first cycle where `hready` is high again. The bench drives and samples on the falling edge. It records select, address, command and the union of write enables over the low cycles, counts those cycles against the arithmetic expectation, and reads `hrdata` in the cycle `hready` returns. A reference memory in the bench, updated from the requirements' lane rules, supplies the expected read words. These words show whether writes landed, including the writes to the ROM that must have no effect.

// File: rtl/smc_pkg.sv
`timescale 1ns/1ps
package smc_pkg;
  typedef enum logic [1:0] {
    CMD_RAM_WR = 2'b00,
    CMD_RAM_RD = 2'b01,
    CMD_ROM_RD = 2'b10,
    CMD_DROP   = 2'b11
  } smc_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER,
    ST_DONE
  } smc_state_e;
endpackage

// File: rtl/smc_bank_decode.sv
`timescale 1ns/1ps
module smc_bank_decode #(
  parameter int NBANK    = 4,
  parameter int ROM_BANK = NBANK - 1,
  localparam int BANK_W  = $clog2(NBANK)
) (
  input  logic [BANK_W-1:0] region,
  input  logic              remap,
  output logic [BANK_W-1:0] bank,
  output logic              is_rom
);
  // Region zero aliases the boot ROM until the map is switched.
  always_comb begin
    if (region == '0 && !remap) bank = BANK_W'(ROM_BANK);
    else                        bank = region;
    is_rom = (bank == BANK_W'(ROM_BANK));
  end
endmodule

// File: rtl/smc_lane_mask.sv
`timescale 1ns/1ps
module smc_lane_mask #(
  parameter int LANES  = 4,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic [2:0]        size,
  input  logic [LANE_W-1:0] offset,
  output logic [LANES-1:0]  mask
);
  // A lane is enabled when it falls in the same size-aligned group as the offset.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      mask[i] = ((i >> size) == (int'(offset) >> size));
    end
  end
endmodule

// File: rtl/smc_seq.sv
`timescale 1ns/1ps
module smc_seq
  import smc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [WAIT_W-1:0] wait_cnt,
  output smc_state_e        state,
  output logic              last_strobe
);
  logic [WAIT_W-1:0] cnt_q;

  assign last_strobe = (state == ST_STROBE) && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE:    if (accept) state <= ST_SETUP;
        ST_SETUP: begin
          state <= ST_STROBE;
          cnt_q <= wait_cnt;
        end
        ST_STROBE: begin
          if (cnt_q == '0) state <= ST_RECOVER;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_RECOVER: state <= ST_DONE;
        ST_DONE:    state <= accept ? ST_SETUP : ST_IDLE;
        default:    state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/static_mem_ctrl.sv
`timescale 1ns/1ps
module static_mem_ctrl
  import smc_pkg::*;
#(
  parameter int NBANK    = 4,
  parameter int ROM_BANK = NBANK - 1,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 26,
  parameter int WAIT_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    hsel,
  input  logic [31:0]             haddr,
  input  logic [1:0]              htrans,
  input  logic                    hwrite,
  input  logic [2:0]              hsize,
  input  logic [DATA_W-1:0]       hwdata,
  output logic [DATA_W-1:0]       hrdata,
  output logic                    hready,
  output logic                    hresp,
  input  logic                    remap,
  input  logic [NBANK*WAIT_W-1:0] bank_wait,
  output logic [NBANK-1:0]        mem_cs_n,
  output logic [DATA_W/8-1:0]     mem_we_n,
  output logic                    mem_oe_n,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    mem_wdata_oe,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic [1:0]              acc_cmd
);
  localparam int LANES   = DATA_W / 8;
  localparam int LANE_W  = $clog2(LANES);
  localparam int BANK_W  = $clog2(NBANK);
  localparam int REG_LSB = ADDR_W + LANE_W;

  logic unused_hbits;
  assign unused_hbits = ^{haddr[31:REG_LSB+BANK_W], htrans[0]};

  smc_state_e        state;
  logic              last_strobe;
  logic              accept;
  logic              in_acc;
  logic [BANK_W-1:0] dec_bank, bank_q;
  logic              dec_rom, rom_q, write_q;
  logic [LANES-1:0]  lane_mask, mask_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  smc_cmd_e          cmd_d, cmd_q;
  logic [WAIT_W-1:0] bank_wait_sel;

  assign hready = (state == ST_IDLE) || (state == ST_DONE);
  assign accept = hready && hsel && htrans[1];
  assign in_acc = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_RECOVER);

  smc_bank_decode #(.NBANK(NBANK), .ROM_BANK(ROM_BANK)) u_decode (
    .region (haddr[REG_LSB +: BANK_W]),
    .remap  (remap),
    .bank   (dec_bank),
    .is_rom (dec_rom)
  );

  smc_lane_mask #(.LANES(LANES)) u_lanes (
    .size   (hsize),
    .offset (haddr[LANE_W-1:0]),
    .mask   (lane_mask)
  );

  assign bank_wait_sel = bank_wait[int'(bank_q)*WAIT_W +: WAIT_W];

  smc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .wait_cnt    (bank_wait_sel),
    .state       (state),
    .last_strobe (last_strobe)
  );

  always_comb begin
    if (hwrite) cmd_d = dec_rom ? CMD_DROP   : CMD_RAM_WR;
    else        cmd_d = dec_rom ? CMD_ROM_RD : CMD_RAM_RD;
  end

  // Address-phase capture.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q  <= '0;
      rom_q   <= 1'b0;
      write_q <= 1'b0;
      mask_q  <= '0;
      addr_q  <= '0;
      cmd_q   <= CMD_RAM_RD;
    end else if (accept) begin
      bank_q  <= dec_bank;
      rom_q   <= dec_rom;
      write_q <= hwrite;
      mask_q  <= lane_mask;
      addr_q  <= haddr[REG_LSB-1:LANE_W];
      cmd_q   <= cmd_d;
    end
  end

  // Data-phase capture: write data in setup, read data at end of strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (state == ST_SETUP)       wdata_q <= hwdata;
      if (last_strobe && !write_q) rdata_q <= mem_rdata;
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_cs
    assign mem_cs_n[b] = ~(in_acc && (bank_q == BANK_W'(b)));
  end

  assign mem_wdata_oe = (state == ST_STROBE) && write_q && !rom_q;
  assign mem_we_n     = mem_wdata_oe ? ~mask_q : '1;
  assign mem_oe_n     = ~(in_acc && !write_q);
  assign mem_wdata    = wdata_q;
  assign mem_addr     = addr_q;
  assign hrdata       = rdata_q;
  assign hresp        = 1'b0;
  assign acc_cmd      = cmd_q;
endmodule

// File: rtl/smc_chk.sv
`timescale 1ns/1ps
module smc_chk #(
  parameter int NBANK    = 4,
  parameter int ROM_BANK = NBANK - 1,
  parameter int LANES    = 4,
  parameter int ADDR_W   = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hsel,
  input logic [1:0]        htrans,
  input logic              hready,
  input logic [NBANK-1:0]  mem_cs_n,
  input logic [LANES-1:0]  mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_wdata_oe,
  input logic [ADDR_W-1:0] mem_addr
);
  logic take;
  assign take = hready && hsel && htrans[1];

  AST_CS_AT_MOST_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1); // R3
  AST_CS_OFF_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    hready |-> (&mem_cs_n)); // R3
  AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && !$past(hready)) |-> ($stable(mem_cs_n) && $stable(mem_addr))); // R3
  AST_ACCEPT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (!hready && !(&mem_cs_n))); // R7
  AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n[ROM_BANK] |-> (&mem_we_n)); // R9
  AST_WE_WITH_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mem_we_n) |-> (mem_wdata_oe && !(&mem_cs_n))); // R11
  AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_wdata_oe); // R11
endmodule

bind static_mem_ctrl smc_chk #(
  .NBANK(NBANK), .ROM_BANK(ROM_BANK), .LANES(DATA_W/8), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .hsel(hsel), .htrans(htrans), .hready(hready),
  .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_wdata_oe(mem_wdata_oe), .mem_addr(mem_addr)
);

// File: tb/static_mem_ctrl_tb.sv
`timescale 1ns/1ps
module static_mem_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hsel = 1'b0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = 2'b00;
  logic        hwrite = 1'b0;
  logic [2:0]  hsize = 3'd2;
  logic [31:0] hwdata = '0;
  logic [31:0] hrdata;
  logic        hready, hresp;
  logic        remap = 1'b1;
  logic [15:0] bank_wait = {4'd2, 4'd0, 4'd3, 4'd1};
  logic [3:0]  mem_cs_n, mem_we_n;
  logic        mem_oe_n, mem_wdata_oe;
  logic [25:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [1:0]  acc_cmd;

  int n_checks = 0;
  int n_fails  = 0;
  logic [31:0] dev [4][16];
  logic [31:0] refm [4][16];

  always #4 clk = ~clk;

  static_mem_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp), .remap(remap), .bank_wait(bank_wait),
    .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
    .mem_rdata(mem_rdata), .acc_cmd(acc_cmd)
  );

  // External device model: four banks of 16 words.
  always_comb begin
    mem_rdata = '0;
    for (int b = 0; b < 4; b++)
      if (!mem_cs_n[b] && !mem_oe_n) mem_rdata = dev[b][mem_addr[3:0]];
  end

  always @(posedge clk) begin
    for (int b = 0; b < 4; b++)
      if (!mem_cs_n[b])
        for (int l = 0; l < 4; l++)
          if (!mem_we_n[l]) dev[b][mem_addr[3:0]][8*l +: 8] <= mem_wdata[8*l +: 8];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input bit wr, input int sz, input logic [31:0] d);
    int   bank, w, off, low, wt;
    bit   rom, first, csdiff;
    logic [3:0]  exp_mask, we_acc, cs0;
    logic [1:0]  exp_cmd, cmd0;
    logic [25:0] addr0;
    bank = int'(a[29:28]);
    if (bank == 0 && !remap) bank = 3;
    rom = (bank == 3);
    w   = int'(a[5:2]);
    off = int'(a[1:0]);
    wt  = int'(bank_wait[bank*4 +: 4]);
    case (sz)
      0:       exp_mask = 4'b0001 << off;
      1:       exp_mask = a[1] ? 4'b1100 : 4'b0011;
      default: exp_mask = 4'b1111;
    endcase
    if (!wr || rom) exp_mask = 4'b0000;
    if (wr) exp_cmd = rom ? 2'b11 : 2'b00;
    else    exp_cmd = rom ? 2'b10 : 2'b01;

    hsel = 1'b1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = 3'(sz);
    @(posedge clk);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00; hwdata = d;
    low = 0; first = 1'b1; csdiff = 1'b0; we_acc = '0;
    cs0 = '1; cmd0 = '0; addr0 = '0;
    while (!hready && low < 40) begin
      if (first) begin
        cs0 = mem_cs_n; cmd0 = acc_cmd; addr0 = mem_addr; first = 1'b0;
      end else if (mem_cs_n != cs0) csdiff = 1'b1;
      we_acc |= ~mem_we_n;
      low++;
      @(negedge clk);
    end
    chk(low == 3 + wt, "R7/R8 stall length", 32'(low), 32'(3 + wt));
    chk(cs0 == ~(4'b0001 << bank), "R1/R2 chip select", {28'd0, cs0}, {28'd0, ~(4'b0001 << bank)});
    chk(!csdiff, "R3 select held", {31'd0, csdiff}, 32'd0);
    chk(hready && (&mem_cs_n), "R3 idle selects", {27'd0, hready, mem_cs_n}, 32'h1f);
    chk(addr0 == a[27:2], "R5 external address", {6'd0, addr0}, {6'd0, a[27:2]});
    chk(cmd0 == exp_cmd, "R6 command code", {30'd0, cmd0}, {30'd0, exp_cmd});
    chk(we_acc == exp_mask, rom ? "R9 rom write enables" : "R4 lane enables",
        {28'd0, we_acc}, {28'd0, exp_mask});
    chk(hresp == 1'b0, "R12 response", {31'd0, hresp}, 32'd0);
    if (!wr) chk(hrdata == refm[bank][w], rom ? "R10/R9 rom read" : "R10 read data", hrdata, refm[bank][w]);
    if (wr && !rom)
      for (int l = 0; l < 4; l++)
        if (exp_mask[l]) refm[bank][w][8*l +: 8] = d[8*l +: 8];
  endtask

  function automatic logic [31:0] mk_addr(input int region, input int w, input int off);
    logic [21:0] hi;
    hi = 22'(region * 37 + w * 1001 + 5);
    return {2'b00, 2'(region), hi, 4'(w), 2'(off)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 16; w++) begin
        dev[b][w]  = {8'(b), 8'(w), 8'hA5, 8'(b * 16 + w) ^ 8'h3C};
        refm[b][w] = {8'(b), 8'(w), 8'hA5, 8'(b * 16 + w) ^ 8'h3C};
      end
    repeat (3) @(negedge clk);
    // R3: reset state
    chk(hready && (&mem_cs_n) && (&mem_we_n) && !hresp, "R3 reset state",
        {23'd0, hready, mem_cs_n, mem_we_n, hresp}, {23'd0, 1'b1, 4'hf, 4'hf, 1'b0});
    rst_n = 1'b1;
    @(negedge clk);

    // R4/R1: every size and aligned offset on every bank, then read back.
    remap = 1'b1;
    for (int b = 0; b < 4; b++)
      for (int sz = 0; sz < 3; sz++)
        for (int off = 0; off < 4; off += (1 << sz)) begin
          int w;
          logic [31:0] d;
          w = (b * 3 + off + sz * 5) % 16;
          d = 32'h1357_9BDF ^ (32'(b * 64 + sz * 16 + off) * 32'h0101_0101);
          xfer(mk_addr(b, w, off), 1'b1, sz, d);
          xfer(mk_addr(b, w, 0), 1'b0, 2, 32'd0);
        end

    // R10: full read sweep of all banks.
    for (int b = 0; b < 4; b++)
      for (int w = 0; w < 16; w++)
        xfer(mk_addr(b, w, 0), 1'b0, 2, 32'd0);

    // R2: boot map, region 0 reaches the ROM; writes there are dropped (R9).
    remap = 1'b0;
    for (int w = 0; w < 16; w++) xfer(mk_addr(0, w, 0), 1'b0, 2, 32'd0);
    for (int w = 0; w < 4; w++)  xfer(mk_addr(0, w, w), 1'b1, 0, 32'hDEAD_BEEF);
    xfer(mk_addr(3, 5, 0), 1'b1, 2, 32'hFFFF_0000);
    for (int w = 0; w < 6; w++)  xfer(mk_addr(3, w, 0), 1'b0, 2, 32'd0);

    // R2: back to run map, region 0 is RAM bank 0 again.
    remap = 1'b1;
    for (int w = 0; w < 4; w++) xfer(mk_addr(0, w, 0), 1'b0, 2, 32'd0);

    // R8: largest wait count on bank 2.
    bank_wait = {4'd2, 4'd15, 4'd3, 4'd1};
    xfer(mk_addr(2, 9, 2), 1'b1, 1, 32'hA1B2_C3D4);
    xfer(mk_addr(2, 9, 0), 1'b0, 2, 32'd0);
    bank_wait = {4'd0, 4'd0, 4'd0, 4'd0};
    xfer(mk_addr(1, 7, 3), 1'b1, 0, 32'h5A00_0000);
    xfer(mk_addr(1, 7, 0), 1'b0, 2, 32'd0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule